// File: doc/BRIEF.md
# Input Bus Parity Checker

This block watches the words arriving at a DAC data input port and checks the parity bit that comes with each of them. It runs on one clock that stands for the data clock. With the 32-bit bus width the port is double rate: each clock delivers a pair of words, already split into lane A (first edge) and lane B (second edge). With any other width the port is single rate and only lane A carries a word, one per clock.

A 2-bit mode input selects one of four checks: off, even parity, odd parity, or a channel-tag check. In the tag check the parity bit does not cover the data at all. It must read 0 on an I-channel word and 1 on a Q-channel word. The block keeps track of the I/Q phase itself, and a rising frame-sync input re-aligns that phase. Every captured word is checked, whatever the frame-sync level.

Results come out as a registered error pulse per lane, a sticky flag with a synchronous clear, and a saturating error counter.

Top module: `pchk_top`

## Requirements
- R1: The mode encoding is 2'b00 off, 2'b01 channel tag, 2'b10 even, 2'b11 odd. In even mode a word fails when the XOR of its data bits and its parity bit is 1.
- R2: In odd mode a word fails when the XOR of its data bits and its parity bit is 0.
- R3: In channel-tag mode the parity bit must be 0 on an I word and 1 on a Q word. In double-rate mode lane A is always I and lane B is always Q.
- R4: In single-rate channel-tag mode the phase alternates I, Q, I, … from one clock to the next. A clock where frame sync is high and was low on the clock before carries an I word. Apart from that, frame sync has no effect on any check.
- R5: Width code 2'b10 (32-bit) selects double rate, and both lanes are checked. Any other code selects single rate: only lane A is checked, and err_pulse_o[1] stays 0.
- R6: err_pulse_o[k] is high for one clock, one clock after the edge that sampled a failing word on lane k.
- R7: In mode off, err_pulse_o stays 0 and the sticky flag does not change.
- R8: The sticky flag sets on any word error and holds until clr_i. A clr_i in the same clock as an error wins.
- R9: The counter adds 0, 1 or 2 failing words per clock and saturates at all ones.
- R10: A clock whose mode or width differs from the previous clock resets the I/Q phase to I. On that clock the counter restarts and holds only that clock's failures.
- R11: After reset the pulses, the sticky flag and the counter are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | data clock |
| rst_n | input | 1 | active-low asynchronous reset |
| mode_i | input | 2 | check mode |
| width_i | input | 2 | bus width code, 2'b10 = 32-bit double rate |
| fsync_i | input | 1 | frame sync |
| word_a_i | input | DW | word on first edge (the only word in single rate) |
| par_a_i | input | 1 | parity bit of word_a_i |
| word_b_i | input | DW | word on second edge (double rate) |
| par_b_i | input | 1 | parity bit of word_b_i |
| clr_i | input | 1 | synchronous clear of the sticky flag |
| err_pulse_o | output | 2 | per-lane error pulse, bit 0 = lane A |
| err_sticky_o | output | 1 | sticky error flag |
| err_cnt_o | output | CW | saturating error count |

## Verification
The bench builds the block with DW=8 and CW=4. The narrow word keeps the parity of each hand-picked vector easy to see. The 4-bit counter brings saturation within a few clocks of two failures each, so the step from 14 to 15 with an increment of 2 is covered, as is the hold at 15. The vectors move between every mode and width code so that each configuration change restarts the counter and re-aligns the phase. Frame sync is raised and held to separate a rising edge from a steady high level.

// File: rtl/pchk_pkg.sv
package pchk_pkg;

    typedef enum logic [1:0] {
        PM_OFF  = 2'b00,
        PM_IQ   = 2'b01,
        PM_EVEN = 2'b10,
        PM_ODD  = 2'b11
    } pmode_e;

    localparam logic [1:0] BW_DDR_CODE = 2'b10;
    localparam int unsigned NUM_LANES  = 2;

endpackage

// File: rtl/pchk_lane.sv
module pchk_lane
    import pchk_pkg::*;
#(
    parameter int unsigned DW = 16
) (
    input  pmode_e          mode_i,
    input  logic            en_i,
    input  logic [DW-1:0]   word_i,
    input  logic            par_i,
    input  logic            is_q_i,
    output logic            err_o
);

    logic xor_all;

    always_comb begin
        xor_all = ^{word_i, par_i};
        err_o   = 1'b0;
        if (en_i) begin
            unique case (mode_i)
                PM_IQ:   err_o = (par_i != is_q_i);
                PM_EVEN: err_o = xor_all;
                PM_ODD:  err_o = ~xor_all;
                default: err_o = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/pchk_iq_phase.sv
module pchk_iq_phase (
    input  logic clk,
    input  logic rst_n,
    input  logic ddr_i,
    input  logic sync_rise_i,
    input  logic restart_i,
    output logic lane_a_is_q_o,
    output logic lane_b_is_q_o
);

    typedef struct packed {
        logic phase;
    } ph_state_t;

    ph_state_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        lane_b_is_q_o = 1'b1;
        if (ddr_i) begin
            lane_a_is_q_o = 1'b0;
            st_d.phase    = 1'b0;
        end else begin
            lane_a_is_q_o = (sync_rise_i || restart_i) ? 1'b0 : st_q.phase;
            st_d.phase    = ~lane_a_is_q_o;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4: in single rate with no re-alignment, the phase flips each clock
    assert_phase_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ddr_i && !sync_rise_i && !restart_i) |=> (st_q.phase != $past(st_q.phase)));

    // R4/R10: a re-aligned single-rate word is followed by a Q phase
    assert_realign_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ddr_i && (sync_rise_i || restart_i)) |=> (st_q.phase == 1'b1));

endmodule

// File: rtl/pchk_accum.sv
module pchk_accum
    import pchk_pkg::*;
#(
    parameter int unsigned CW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 restart_i,
    input  logic [NUM_LANES-1:0] err_i,
    input  logic                 clr_i,
    output logic [NUM_LANES-1:0] pulse_o,
    output logic                 sticky_o,
    output logic [CW-1:0]        cnt_o
);

    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    typedef struct packed {
        logic [NUM_LANES-1:0] pulse;
        logic                 sticky;
        logic [CW-1:0]        cnt;
    } acc_state_t;

    acc_state_t st_d, st_q;
    logic [CW:0] inc;
    logic [CW:0] sum;

    always_comb begin
        st_d       = st_q;
        inc        = {{CW{1'b0}}, err_i[0]} + {{CW{1'b0}}, err_i[1]};
        sum        = {1'b0, st_q.cnt} + inc;
        st_d.pulse = err_i;
        if (clr_i)           st_d.sticky = 1'b0;
        else if (|err_i)     st_d.sticky = 1'b1;
        if (restart_i)       st_d.cnt = inc[CW-1:0];
        else if (sum[CW])    st_d.cnt = CNT_MAX;
        else                 st_d.cnt = sum[CW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse_o  = st_q.pulse;
    assign sticky_o = st_q.sticky;
    assign cnt_o    = st_q.cnt;

    assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !sticky_o);

    assert_sticky_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky_o && !clr_i) |=> sticky_o);

    assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o == CNT_MAX && !restart_i) |=> (cnt_o == CNT_MAX));

    assert_monotonic_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !restart_i |=> (cnt_o >= $past(cnt_o)));

endmodule

// File: rtl/pchk_top.sv
module pchk_top
    import pchk_pkg::*;
#(
    parameter int unsigned DW = 16,
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode_i,
    input  logic [1:0]    width_i,
    input  logic          fsync_i,
    input  logic [DW-1:0] word_a_i,
    input  logic          par_a_i,
    input  logic [DW-1:0] word_b_i,
    input  logic          par_b_i,
    input  logic          clr_i,
    output logic [1:0]    err_pulse_o,
    output logic          err_sticky_o,
    output logic [CW-1:0] err_cnt_o
);

    typedef struct packed {
        logic [1:0] mode;
        logic [1:0] width;
        logic       fsync;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    pmode_e               mode_e;
    logic                 ddr;
    logic                 cfg_chg;
    logic                 sync_rise;
    logic [NUM_LANES-1:0] lane_en;
    logic [NUM_LANES-1:0] lane_is_q;
    logic [NUM_LANES-1:0] lane_par;
    logic [NUM_LANES-1:0] lane_err;
    logic [DW-1:0]        lane_word [NUM_LANES];

    always_comb begin
        mode_e       = pmode_e'(mode_i);
        ddr          = (width_i == BW_DDR_CODE);
        cfg_chg      = (mode_i != st_q.mode) || (width_i != st_q.width);
        sync_rise    = fsync_i && !st_q.fsync;
        lane_en      = {ddr, 1'b1};
        lane_par     = {par_b_i, par_a_i};
        lane_word[0] = word_a_i;
        lane_word[1] = word_b_i;
        st_d.mode    = mode_i;
        st_d.width   = width_i;
        st_d.fsync   = fsync_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    pchk_iq_phase u_phase (
        .clk           (clk),
        .rst_n         (rst_n),
        .ddr_i         (ddr),
        .sync_rise_i   (sync_rise),
        .restart_i     (cfg_chg),
        .lane_a_is_q_o (lane_is_q[0]),
        .lane_b_is_q_o (lane_is_q[1])
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        pchk_lane #(.DW(DW)) u_lane (
            .mode_i (mode_e),
            .en_i   (lane_en[g]),
            .word_i (lane_word[g]),
            .par_i  (lane_par[g]),
            .is_q_i (lane_is_q[g]),
            .err_o  (lane_err[g])
        );
    end

    pchk_accum #(.CW(CW)) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (cfg_chg),
        .err_i     (lane_err),
        .clr_i     (clr_i),
        .pulse_o   (err_pulse_o),
        .sticky_o  (err_sticky_o),
        .cnt_o     (err_cnt_o)
    );

    assert_sdr_lane_b_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (width_i != BW_DDR_CODE) |=> (err_pulse_o[1] == 1'b0));

    assert_off_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == PM_OFF) |=> (err_pulse_o == 2'b00));

    assert_off_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == PM_OFF && !clr_i) |=> $stable(err_sticky_o));

endmodule

// File: tb/pchk_top_bench.sv
`timescale 1ns/1ps
module pchk_top_bench;

    localparam int unsigned DW = 8;
    localparam int unsigned CW = 4;
    localparam logic [CW-1:0] CMAX = {CW{1'b1}};
    localparam int NV = 23;

    // {mode[2], width[2], fsync, word_a[8], par_a, word_b[8], par_b, clr, expected pulse[2]}
    localparam logic [25:0] VEC [NV] = '{
        {2'b10, 2'b00, 1'b0, 8'h03, 1'b0, 8'h01, 1'b0, 1'b0, 2'b00}, // R1 even ok
        {2'b10, 2'b00, 1'b0, 8'h07, 1'b0, 8'h01, 1'b0, 1'b0, 2'b01}, // R1 even fail
        {2'b10, 2'b00, 1'b0, 8'h07, 1'b1, 8'h00, 1'b0, 1'b0, 2'b00}, // R1
        {2'b11, 2'b00, 1'b0, 8'h07, 1'b0, 8'h00, 1'b0, 1'b0, 2'b00}, // R2 odd ok, R10
        {2'b11, 2'b00, 1'b0, 8'h03, 1'b0, 8'h00, 1'b0, 1'b0, 2'b01}, // R2 odd fail
        {2'b11, 2'b10, 1'b0, 8'h03, 1'b1, 8'h00, 1'b0, 1'b0, 2'b10}, // R5 ddr lane b
        {2'b11, 2'b10, 1'b0, 8'h00, 1'b0, 8'hFF, 1'b0, 1'b0, 2'b11}, // R9 two per clock
        {2'b10, 2'b10, 1'b0, 8'hFF, 1'b0, 8'h01, 1'b1, 1'b0, 2'b00}, // R1 ddr
        {2'b01, 2'b10, 1'b0, 8'h5A, 1'b0, 8'h5A, 1'b1, 1'b0, 2'b00}, // R3 I=0 Q=1
        {2'b01, 2'b10, 1'b0, 8'h5A, 1'b1, 8'h5A, 1'b0, 1'b0, 2'b11}, // R3 swapped
        {2'b01, 2'b00, 1'b0, 8'h5A, 1'b0, 8'h5A, 1'b0, 1'b0, 2'b00}, // R10 phase I
        {2'b01, 2'b00, 1'b0, 8'h5A, 1'b1, 8'h00, 1'b0, 1'b0, 2'b00}, // R4 Q
        {2'b01, 2'b00, 1'b0, 8'h5A, 1'b1, 8'h00, 1'b0, 1'b0, 2'b01}, // R4 I, tag 1
        {2'b01, 2'b00, 1'b1, 8'h5A, 1'b0, 8'h00, 1'b0, 1'b0, 2'b00}, // R4 rise -> I
        {2'b01, 2'b00, 1'b1, 8'h5A, 1'b0, 8'h00, 1'b0, 1'b0, 2'b01}, // R4 held -> Q
        {2'b01, 2'b00, 1'b0, 8'h5A, 1'b0, 8'h00, 1'b0, 1'b0, 2'b00}, // R4 I
        {2'b00, 2'b00, 1'b0, 8'h07, 1'b0, 8'h00, 1'b1, 1'b0, 2'b00}, // R7 off
        {2'b00, 2'b10, 1'b0, 8'h07, 1'b0, 8'h00, 1'b0, 1'b0, 2'b00}, // R7 off ddr
        {2'b10, 2'b11, 1'b0, 8'h01, 1'b0, 8'h01, 1'b0, 1'b0, 2'b01}, // R5 sdr lane b ignored
        {2'b10, 2'b11, 1'b0, 8'h01, 1'b0, 8'h01, 1'b0, 1'b1, 2'b01}, // R8 clear wins
        {2'b10, 2'b11, 1'b0, 8'h03, 1'b0, 8'h01, 1'b0, 1'b0, 2'b00}, // R8 stays low
        {2'b10, 2'b11, 1'b1, 8'h03, 1'b0, 8'h01, 1'b0, 1'b0, 2'b00}, // R4 fsync no effect
        {2'b10, 2'b11, 1'b0, 8'h07, 1'b0, 8'h01, 1'b0, 1'b0, 2'b01}  // R6 pulse
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic [1:0]    mode_i, width_i;
    logic          fsync_i, par_a_i, par_b_i, clr_i;
    logic [DW-1:0] word_a_i, word_b_i;
    logic [1:0]    err_pulse_o;
    logic          err_sticky_o;
    logic [CW-1:0] err_cnt_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [1:0]    m_mode, m_width;
    logic          m_stk;
    logic [CW-1:0] m_cnt;

    always #2.5 clk = ~clk;

    pchk_top #(.DW(DW), .CW(CW)) u_pchk_top (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .width_i(width_i),
        .fsync_i(fsync_i), .word_a_i(word_a_i), .par_a_i(par_a_i),
        .word_b_i(word_b_i), .par_b_i(par_b_i), .clr_i(clr_i),
        .err_pulse_o(err_pulse_o), .err_sticky_o(err_sticky_o), .err_cnt_o(err_cnt_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_vec(input logic [25:0] v, input string req);
        int sum;
        mode_i   = v[25:24];
        width_i  = v[23:22];
        fsync_i  = v[21];
        word_a_i = v[20:13];
        par_a_i  = v[12];
        word_b_i = v[11:4];
        par_b_i  = v[3];
        clr_i    = v[2];
        @(posedge clk);
        @(negedge clk);
        sum = int'(v[0]) + int'(v[1]);
        if (v[25:24] != m_mode || v[23:22] != m_width) m_cnt = CW'(sum);
        else if (int'(m_cnt) + sum > int'(CMAX)) m_cnt = CMAX;
        else m_cnt = m_cnt + CW'(sum);
        m_mode  = v[25:24];
        m_width = v[23:22];
        if (v[2]) m_stk = 1'b0;
        else if (v[1:0] != 2'b00) m_stk = 1'b1;
        chk({req, " pulse"}, int'(err_pulse_o), int'(v[1:0]));
        chk("R8 sticky", int'(err_sticky_o), int'(m_stk));
        chk("R9 count", int'(err_cnt_o), int'(m_cnt));
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        mode_i = 2'b00; width_i = 2'b00; fsync_i = 1'b0; clr_i = 1'b0;
        word_a_i = '0; word_b_i = '0; par_a_i = 1'b0; par_b_i = 1'b0;
        m_mode = 2'b00; m_width = 2'b00; m_stk = 1'b0; m_cnt = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 reset pulse", int'(err_pulse_o), 0);
        chk("R11 reset sticky", int'(err_sticky_o), 0);
        chk("R11 reset count", int'(err_cnt_o), 0);

        for (int i = 0; i < NV; i++) run_vec(VEC[i], "R6 vector");

        // R9 saturation: two failures per clock in double-rate even mode
        for (int k = 0; k < 9; k++)
            run_vec({2'b10, 2'b10, 1'b0, 8'h00, 1'b1, 8'h00, 1'b1, 1'b0, 2'b11}, "R9 sat");
        chk("R9 saturated", int'(err_cnt_o), int'(CMAX));

        // R10 width change alone restarts the counter
        run_vec({2'b10, 2'b00, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 2'b00}, "R10 restart");
        chk("R10 count zero", int'(err_cnt_o), 0);

        // R11 reset in mid-run
        rst_n = 1'b0;
        #1;
        chk("R11 async sticky", int'(err_sticky_o), 0);
        chk("R11 async count", int'(err_cnt_o), 0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule